// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Level and Edge Interrupt Sensing

This block is a bank of general-purpose pins on a small word-addressed register bus. Each pin has an output data bit, a direction bit, an input-path enable, a sense polarity, an edge-or-level choice, a dual-edge choice, two independent interrupt masks and a function-enable bit. The function-enable bit hands the pin to an alternate peripheral. The data register and both mask registers each take four kinds of write: a whole-word write and write-one-to-set, write-one-to-clear and write-one-to-toggle aliases. Software can therefore change single bits without a read-modify-write sequence.

Pin inputs pass through a two-flop synchronizer. For pins that are enabled as inputs, the data register either tracks the polarity-adjusted level or latches a detected edge until software clears it. Two registered, active-high interrupt lines are formed from the input-qualified data bits, one through mask A and one through mask B. An asynchronous active-low reset is released synchronously inside the block.

Top module: `gpio_sense_bank`

## Requirements
- R1: After reset every register reads 0, and `pin_oe`, `pin_out`, `alt_sel`, `irq_a` and `irq_b` are all 0.
- R2: Data register offsets: 0 writes the whole word, 1 ORs in the written ones, 2 clears the bits written as one, and 3 inverts the bits written as one. Reading any of these four offsets returns the data register. `bus_rdata` changes only on a read and is valid after the clock edge that samples the read.
- R3: Mask A uses offsets 4 to 7 and mask B uses offsets 8 to 11. Within each group the low two address bits select write, set, clear or toggle, exactly as for the data register. Operations on one register leave the other two alias groups unchanged.
- R4: Offset 12 is the direction register, where 1 means output. `pin_out` always equals the data register. Writing the direction register clears the input-enable bits (offset 13) wherever the written word has a 1.
- R5: Offset 17 is the function-enable register and drives `alt_sel`. `pin_oe` equals direction AND NOT function-enable. A function-enabled pin is never captured into the data register.
- R6: A pin is input-qualified when its input enable is 1, its direction is 0 and its function-enable is 0. A qualified pin with edge bit 0 (offset 15) is level-sensitive. Its data bit follows the synchronized pin level XOR its polarity bit (offset 14), and bus writes to that bit have no effect.
- R7: A qualified pin with edge bit 1 and dual-edge bit 0 (offset 16) latches a 1 on a rising edge when polarity is 0, or on a falling edge when polarity is 1. The bit stays set until it is cleared through the bus.
- R8: A qualified pin with both the edge bit and the dual-edge bit at 1 latches on either transition, whatever its polarity.
- R9: `irq_a` is the registered OR over all pins of data AND qualified AND mask A. `irq_b` is formed the same way with mask B.
- R10: Pins that are not qualified capture nothing, so their data bits change only through the bus. Reads of offsets 18 to 31 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| pin_in | input | 16 | Raw pin levels |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables |
| alt_sel | output | 16 | Pin handed to alternate function |
| irq_a | output | 1 | Interrupt through mask A |
| irq_b | output | 1 | Interrupt through mask B |

## Verification
The alias logic is swept with computed words across all four operations of each alias group. Every result is read back through both the base offset and the alias offset, which separates a wrong operation from a wrong read decode.

The sensing logic is tried with pins configured so that the sixteen pins cover all eight combinations of polarity, edge and dual-edge. A rising step, a falling step and two mixed patterns then show whether each mode picks the right transition, whether latched bits hold until cleared, and whether level pins ignore bus writes. Interrupt checks vary the masks, the input enables and the function enables, which tells masking apart from qualification.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int unsigned GPB_AW = 5;

  // Offsets 0..11: three alias groups; the low two bits pick the operation.
  localparam logic [GPB_AW-1:0] OFS_DATA  = 5'd0;
  localparam logic [GPB_AW-1:0] OFS_MSKA  = 5'd4;
  localparam logic [GPB_AW-1:0] OFS_MSKB  = 5'd8;
  localparam logic [GPB_AW-1:0] OFS_DIR   = 5'd12;
  localparam logic [GPB_AW-1:0] OFS_INEN  = 5'd13;
  localparam logic [GPB_AW-1:0] OFS_POL   = 5'd14;
  localparam logic [GPB_AW-1:0] OFS_EDGE  = 5'd15;
  localparam logic [GPB_AW-1:0] OFS_BOTH  = 5'd16;
  localparam logic [GPB_AW-1:0] OFS_FUNC  = 5'd17;

  localparam logic [2:0] GRP_DATA = 3'd0;
  localparam logic [2:0] GRP_MSKA = 3'd1;
  localparam logic [2:0] GRP_MSKB = 3'd2;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TGL   = 2'd3
  } gpb_op_e;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv
);
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = pin_in;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign lvl = sync_q;
  assign prv = prev_q;
endmodule

// File: rtl/gpb_sense.sv
module gpb_sense #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] prv,
  input  logic [W-1:0] qual,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] edg,
  input  logic [W-1:0] both,
  output logic [W-1:0] lvl_force,
  output logic [W-1:0] lvl_val,
  output logic [W-1:0] edge_hit
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, hit;
    assign rise         = lvl[i] & ~prv[i];
    assign fall         = ~lvl[i] & prv[i];
    assign hit          = both[i] ? (rise | fall) : (pol[i] ? fall : rise);
    assign edge_hit[i]  = qual[i] & edg[i] & hit;
    assign lvl_force[i] = qual[i] & ~edg[i];
    assign lvl_val[i]   = lvl[i] ^ pol[i];
  end
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
  import gpb_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [GPB_AW-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      lvl_force,
  input  logic [W-1:0]      lvl_val,
  input  logic [W-1:0]      edge_hit,
  output logic [W-1:0]      bus_rdata,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      ma_q,
  output logic [W-1:0]      mb_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      inen_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      edg_q,
  output logic [W-1:0]      both_q,
  output logic [W-1:0]      func_q
);
  logic          wr_en, rd_en;
  logic [2:0]    grp;
  gpb_op_e       op;
  logic [W-1:0]  data_bus;
  logic [W-1:0]  data_d, ma_d, mb_d, dir_d, inen_d, pol_d, edg_d, both_d, func_d;
  logic [W-1:0]  rd_mux, rdata_q, rdata_d;

  function automatic logic [W-1:0] alias_op(input gpb_op_e o,
                                            input logic [W-1:0] cur,
                                            input logic [W-1:0] wv);
    case (o)
      OP_SET:  return cur | wv;
      OP_CLR:  return cur & ~wv;
      OP_TGL:  return cur ^ wv;
      default: return wv;
    endcase
  endfunction

  assign wr_en = bus_valid & bus_write;
  assign rd_en = bus_valid & ~bus_write;
  assign grp   = bus_addr[GPB_AW-1:2];
  assign op    = gpb_op_e'(bus_addr[1:0]);

  always_comb begin
    data_bus = (wr_en && grp == GRP_DATA) ? alias_op(op, data_q, bus_wdata) : data_q;
    data_d   = ((data_bus & ~lvl_force) | (lvl_val & lvl_force)) | edge_hit;
    ma_d     = (wr_en && grp == GRP_MSKA) ? alias_op(op, ma_q, bus_wdata) : ma_q;
    mb_d     = (wr_en && grp == GRP_MSKB) ? alias_op(op, mb_q, bus_wdata) : mb_q;
    dir_d    = (wr_en && bus_addr == OFS_DIR)  ? bus_wdata : dir_q;
    pol_d    = (wr_en && bus_addr == OFS_POL)  ? bus_wdata : pol_q;
    edg_d    = (wr_en && bus_addr == OFS_EDGE) ? bus_wdata : edg_q;
    both_d   = (wr_en && bus_addr == OFS_BOTH) ? bus_wdata : both_q;
    func_d   = (wr_en && bus_addr == OFS_FUNC) ? bus_wdata : func_q;
    if (wr_en && bus_addr == OFS_INEN)     inen_d = bus_wdata;
    else if (wr_en && bus_addr == OFS_DIR) inen_d = inen_q & ~bus_wdata;
    else                                   inen_d = inen_q;
  end

  always_comb begin
    rd_mux = '0;
    case (grp)
      GRP_DATA: rd_mux = data_q;
      GRP_MSKA: rd_mux = ma_q;
      GRP_MSKB: rd_mux = mb_q;
      default: begin
        case (bus_addr)
          OFS_DIR:  rd_mux = dir_q;
          OFS_INEN: rd_mux = inen_q;
          OFS_POL:  rd_mux = pol_q;
          OFS_EDGE: rd_mux = edg_q;
          OFS_BOTH: rd_mux = both_q;
          OFS_FUNC: rd_mux = func_q;
          default:  rd_mux = '0;
        endcase
      end
    endcase
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      ma_q    <= '0;
      mb_q    <= '0;
      dir_q   <= '0;
      inen_q  <= '0;
      pol_q   <= '0;
      edg_q   <= '0;
      both_q  <= '0;
      func_q  <= '0;
      rdata_q <= '0;
    end else begin
      data_q  <= data_d;
      ma_q    <= ma_d;
      mb_q    <= mb_d;
      dir_q   <= dir_d;
      inen_q  <= inen_d;
      pol_q   <= pol_d;
      edg_q   <= edg_d;
      both_q  <= both_d;
      func_q  <= func_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpb_irq.sv
module gpb_irq #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data,
  input  logic [W-1:0] qual,
  input  logic [W-1:0] ma,
  input  logic [W-1:0] mb,
  output logic         irq_a,
  output logic         irq_b
);
  logic a_d, b_d, a_q, b_q;

  always_comb begin
    a_d = |(data & qual & ma);
    b_d = |(data & qual & mb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign irq_a = a_q;
  assign irq_b = b_q;
endmodule

// File: rtl/gpio_sense_bank.sv
module gpio_sense_bank
  import gpb_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [GPB_AW-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      alt_sel,
  output logic              irq_a,
  output logic              irq_b
);
  logic [1:0]   rst_pipe;
  logic         rst_n_int;
  logic [W-1:0] lvl, prv, qual, lvl_force, lvl_val, edge_hit;
  logic [W-1:0] data_q, ma_q, mb_q, dir_q, inen_q, pol_q, edg_q, both_q, func_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  gpb_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .pin_in(pin_in), .lvl(lvl), .prv(prv)
  );

  assign qual = inen_q & ~dir_q & ~func_q;

  gpb_sense #(.W(W)) u_sense (
    .lvl(lvl), .prv(prv), .qual(qual), .pol(pol_q), .edg(edg_q), .both(both_q),
    .lvl_force(lvl_force), .lvl_val(lvl_val), .edge_hit(edge_hit)
  );

  gpb_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n_int),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata),
    .lvl_force(lvl_force), .lvl_val(lvl_val), .edge_hit(edge_hit),
    .bus_rdata(bus_rdata),
    .data_q(data_q), .ma_q(ma_q), .mb_q(mb_q), .dir_q(dir_q), .inen_q(inen_q),
    .pol_q(pol_q), .edg_q(edg_q), .both_q(both_q), .func_q(func_q)
  );

  gpb_irq #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n_int), .data(data_q), .qual(qual),
    .ma(ma_q), .mb(mb_q), .irq_a(irq_a), .irq_b(irq_b)
  );

  assign pin_out = data_q;
  assign pin_oe  = dir_q & ~func_q;
  assign alt_sel = func_q;
endmodule

// File: rtl/gpio_sense_bank_chk.sv
module gpio_sense_bank_chk
  import gpb_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [GPB_AW-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic [W-1:0]      pin_oe,
  input logic [W-1:0]      alt_sel,
  input logic              irq_a,
  input logic [W-1:0]      data_q,
  input logic [W-1:0]      ma_q,
  input logic [W-1:0]      inen_q,
  input logic [W-1:0]      dir_q,
  input logic [W-1:0]      func_q
);
  logic         wr, data_wr;
  logic [W-1:0] qual;
  assign wr      = bus_valid & bus_write;
  assign data_wr = wr && (bus_addr[GPB_AW-1:2] == GRP_DATA);
  assign qual    = inen_q & ~dir_q & ~func_q;

  AST_OE_NOT_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & alt_sel) == '0); // R5

  AST_DIR_DROPS_INEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_DIR) |=> ((inen_q & $past(bus_wdata)) == '0)); // R4

  AST_DATA_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == (OFS_DATA + 5'd1) && qual == '0)
      |=> ((data_q & $past(bus_wdata)) == $past(bus_wdata))); // R2

  AST_MSKA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == (OFS_MSKA + 5'd2)) |=> ((ma_q & $past(bus_wdata)) == '0)); // R3

  AST_IRQ_A_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ma_q == '0) |=> !irq_a); // R9

  AST_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_wr && qual == '0) |=> (data_q == $past(data_q))); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata)); // R2

  AST_FUNC_IS_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    alt_sel == func_q); // R5
endmodule

bind gpio_sense_bank gpio_sense_bank_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n_int),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_oe(pin_oe), .alt_sel(alt_sel), .irq_a(irq_a),
  .data_q(data_q), .ma_q(ma_q), .inen_q(inen_q), .dir_q(dir_q), .func_q(func_q)
);

// File: tb/test_gpio_sense_bank.sv
`timescale 1ns/1ps
module test_gpio_sense_bank;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [W-1:0]  pin_in = '0;
  logic [W-1:0]  pin_out, pin_oe, alt_sel;
  logic          irq_a, irq_b;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench-side model of the registers
  logic [W-1:0] m_data = '0, m_ma = '0, m_mb = '0, m_dir = '0, m_inen = '0;
  logic [W-1:0] m_pol = '0, m_edg = '0, m_both = '0, m_func = '0, m_pins = '0;

  always #2.5 clk = ~clk;

  gpio_sense_bank #(.W(W)) i_gpio_sense_bank (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] qual_m();
    return m_inen & ~m_dir & ~m_func;
  endfunction

  function automatic logic [W-1:0] op_m(input logic [1:0] o, input logic [W-1:0] c, input logic [W-1:0] v);
    case (o)
      2'd1: return c | v;
      2'd2: return c & ~v;
      2'd3: return c ^ v;
      default: return v;
    endcase
  endfunction

  task automatic refresh_level();
    logic [W-1:0] lv;
    lv = qual_m() & ~m_edg;
    m_data = (m_data & ~lv) | ((m_pins ^ m_pol) & lv);
  endtask

  function automatic logic [W-1:0] read_m(input logic [4:0] a);
    if (a < 5'd4)  return m_data;
    if (a < 5'd8)  return m_ma;
    if (a < 5'd12) return m_mb;
    case (a)
      5'd12: return m_dir;
      5'd13: return m_inen;
      5'd14: return m_pol;
      5'd15: return m_edg;
      5'd16: return m_both;
      5'd17: return m_func;
      default: return '0;
    endcase
  endfunction

  task automatic bus_wr(input logic [4:0] a, input logic [W-1:0] v);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    if (a < 5'd4)       m_data = op_m(a[1:0], m_data, v);
    else if (a < 5'd8)  m_ma   = op_m(a[1:0], m_ma, v);
    else if (a < 5'd12) m_mb   = op_m(a[1:0], m_mb, v);
    else case (a)
      5'd12: begin m_dir = v; m_inen = m_inen & ~v; end
      5'd13: m_inen = v;
      5'd14: m_pol  = v;
      5'd15: m_edg  = v;
      5'd16: m_both = v;
      5'd17: m_func = v;
      default: ;
    endcase
    refresh_level();
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [W-1:0] v);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    v = bus_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [4:0] a);
    logic [W-1:0] v;
    bus_rd(a, v);
    chk($sformatf("%s off=%0d", tag, a), v, read_m(a));
  endtask

  task automatic apply_pins(input logic [W-1:0] nv);
    logic [W-1:0] q, rise, fall, hit;
    q    = qual_m();
    rise = nv & ~m_pins;
    fall = ~nv & m_pins;
    hit  = (m_both & (rise | fall)) | (~m_both & ~m_pol & rise) | (~m_both & m_pol & fall);
    m_data = m_data | (q & m_edg & hit);
    m_pins = nv;
    refresh_level();
    @(negedge clk);
    pin_in = nv;
    repeat (6) @(negedge clk);
  endtask

  task automatic chk_irq(input string tag);
    repeat (3) @(negedge clk);
    chk({tag, " irq_a"}, {15'd0, irq_a}, {15'd0, |(m_data & qual_m() & m_ma)});
    chk({tag, " irq_b"}, {15'd0, irq_b}, {15'd0, |(m_data & qual_m() & m_mb)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state; R10: unmapped offsets read zero
    for (int a = 0; a < 32; a++) chk_reg(a < 18 ? "R1 reset" : "R10 unmapped", 5'(a));
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 pin_out", pin_out, '0);
    chk("R1 alt_sel", alt_sel, '0);
    chk("R1 irq", {14'd0, irq_a, irq_b}, '0);

    // R2/R3: alias sweep over all groups and ops
    for (int g = 0; g < 3; g++) begin
      for (int k = 0; k < 12; k++) begin
        logic [4:0]   a;
        logic [W-1:0] v;
        a = 5'(g * 4 + (k % 4));
        v = W'((k * 16'h3B5 + g * 16'h1111) ^ 16'h9C6A);
        bus_wr(a, v);
        chk_reg(g == 0 ? "R2 base" : "R3 base", 5'(g * 4));
        chk_reg(g == 0 ? "R2 alias" : "R3 alias", a);
      end
    end
    for (int g = 0; g < 3; g++) chk_reg("R3 groups independent", 5'(g * 4));
    chk("R4 pin_out follows data", pin_out, m_data);

    // R4: direction and input enable
    bus_wr(5'd13, 16'hFFFF);
    bus_wr(5'd12, 16'h00F0);
    chk_reg("R4 dir clears inen", 5'd13);
    chk("R4 pin_oe", pin_oe, 16'h00F0);
    chk_reg("R6 level follows pins", 5'd0);
    chk("R4 pin_out", pin_out, m_data);

    // R5: function enable
    bus_wr(5'd17, 16'h0F30);
    chk("R5 pin_oe", pin_oe, 16'h00C0);
    chk("R5 alt_sel", alt_sel, 16'h0F30);
    apply_pins(16'hFFFF);
    chk_reg("R5 func pins not captured", 5'd0);

    // R10: no capture without input enable
    bus_wr(5'd12, 16'h0000);
    bus_wr(5'd17, 16'h0000);
    bus_wr(5'd13, 16'h0000);
    bus_wr(5'd0, 16'h1234);
    apply_pins(16'h0000);
    chk_reg("R10 disabled pins ignore input", 5'd0);
    apply_pins(16'hC3C3);
    chk_reg("R10 disabled pins ignore input", 5'd0);
    apply_pins(16'h0000);

    // R6/R7/R8: pins cover all polarity/edge/dual-edge combinations
    bus_wr(5'd14, 16'hAAAA);
    bus_wr(5'd15, 16'hCCCC);
    bus_wr(5'd16, 16'hF0F0);
    bus_wr(5'd13, 16'hFFFF);
    bus_wr(5'd2,  16'hFFFF);
    chk_reg("R6 idle sense", 5'd0);
    apply_pins(16'hFFFF);
    chk_reg("R7 R8 rising step", 5'd0);
    bus_wr(5'd1, 16'hFFFF);
    chk_reg("R6 level ignores set", 5'd0);
    bus_wr(5'd2, 16'hFFFF);
    chk_reg("R7 clear latched", 5'd0);
    apply_pins(16'h0000);
    chk_reg("R7 R8 falling step", 5'd0);
    bus_wr(5'd2, 16'hFFFF);
    apply_pins(16'h5A5A);
    chk_reg("R7 R8 mixed A", 5'd0);
    chk("R6 pin_out", pin_out, m_data);
    apply_pins(16'hA5A5);
    chk_reg("R7 latched stays set", 5'd0);
    bus_wr(5'd3, 16'h0F0F);
    chk_reg("R6 R7 toggle on inputs", 5'd0);

    // R9: interrupts
    bus_wr(5'd4, 16'h00FF);
    bus_wr(5'd8, 16'hFF00);
    chk_irq("R9 split masks");
    bus_wr(5'd2, 16'hFFFF);
    chk_irq("R9 after clear");
    apply_pins(16'h0000);
    chk_irq("R9 after fall");
    bus_wr(5'd6, 16'h00FF);
    chk_irq("R9 mask A cleared");
    bus_wr(5'd4, 16'hFFFF);
    chk_irq("R9 mask A full");
    bus_wr(5'd17, 16'hFFFF);
    chk_irq("R9 R5 func drops qual");
    bus_wr(5'd17, 16'h0000);
    bus_wr(5'd13, 16'h0000);
    chk_irq("R9 inen off");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule